// File: doc/BRIEF.md
# Hot-Insertion Start-Up Sequencer

This block controls the power-up and removal sequence of a bus buffer card that is plugged into a live backplane. It receives undervoltage-lockout flags for two supplies and a raw card-present (connect) signal, all already digitized by analog circuits outside the block. From these it drives two precharge enables, one for the backplane-side bus pins and one for the card-side bus pins. It also drives the enable that allows the serial target interface to run.

A parameter selects one of two variants. In the dual-supply variant, the primary lockout flag controls precharge on the backplane side and the secondary lockout flag controls the card side. In the single-supply variant, the primary flag controls both sides and the secondary flag is ignored. The connect input is debounced by a clock-cycle counter. The interface enable is granted last, only after every relevant lockout has cleared and the filtered connect signal is high. The enable is withdrawn in the same cycle in which a lockout flag reasserts or the filtered connect signal drops.

Top module: `hotswap_seq`

## Requirements
- R1: While reset is asserted, ifaceEn is low and the connect filter output reads 0.
- R2: prechargeBp is high exactly while uvloPri is high (1 = supply in lockout), with no clock edge of delay.
- R3: When DUAL_SUPPLY=1, prechargeCard follows uvloSec with no clock edge of delay. When DUAL_SUPPLY=0, prechargeCard follows uvloPri.
- R4: ifaceEn is high only when uvloPri is low, uvloSec is low (dual variant only) and the filtered connect signal is high. Whenever ifaceEn is high, both precharge outputs are low.
- R5: The filtered connect signal changes only after connRaw has differed from it for FILT_CYCLES consecutive clock edges. A shorter pulse leaves ifaceEn unchanged.
- R6: With all lockouts clear and the filtered connect low, ifaceEn rises on the (FILT_CYCLES+1)-th clock edge after connRaw goes high.
- R7: If any relevant lockout flag asserts, ifaceEn falls in the same cycle, before any clock edge.
- R8: With ifaceEn high, ifaceEn falls on the FILT_CYCLES-th clock edge after connRaw goes low.
- R9: While uvloPri is high the connect filter is held cleared. After uvloPri clears with connRaw already high, ifaceEn rises on the (FILT_CYCLES+1)-th edge.
- R10: When DUAL_SUPPLY=0, uvloSec has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| uvloPri | input | 1 | Primary supply lockout flag, 1 = in lockout |
| uvloSec | input | 1 | Secondary supply lockout flag, 1 = in lockout |
| connRaw | input | 1 | Unfiltered card-present input, 1 = mated |
| prechargeBp | output | 1 | Precharge enable for the backplane-side bus pins |
| prechargeCard | output | 1 | Precharge enable for the card-side bus pins |
| ifaceEn | output | 1 | Enable for the serial target interface |

## Verification
A sequencer stuck in its active state would show ifaceEn high while a precharge output is high. The gating makes this visible in the same cycle that the lockout reasserts. A wrong debounce count moves the rising or falling edge of ifaceEn by one or more cycles away from the FILT_CYCLES+1 or FILT_CYCLES edge that the bench expects, so the bench samples exactly on those edges. A filter that is not cleared during primary lockout lets ifaceEn rise only one or two edges after the lockout is released, instead of a full debounce window later.

// File: rtl/hsseq_pkg.sv
package hsseq_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACTIVE = 2'd2
  } seqState_e;

  typedef struct packed {
    logic clrFilt;   // hold the connect debounce cleared
    logic grant;     // sequencer has reached the active state
  } seqStrobe_t;
endpackage

// File: rtl/hsseq_ctrl.sv
module hsseq_ctrl
  import hsseq_pkg::*;
#(
  parameter bit DUAL_SUPPLY = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvloPri,
  input  logic       uvloSec,
  input  logic       connFilt,
  output seqStrobe_t strobe
);
  seqState_e state, nxt;
  logic lockAny;

  generate
    if (DUAL_SUPPLY) begin : g_dual
      assign lockAny = uvloPri | uvloSec;
    end else begin : g_single
      assign lockAny = uvloPri;
    end
  endgenerate

  always_comb begin
    nxt = state;
    unique case (state)
      ST_LOCKED: if (!lockAny) nxt = ST_WAIT;
      ST_WAIT: begin
        if (lockAny)       nxt = ST_LOCKED;
        else if (connFilt) nxt = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (lockAny)        nxt = ST_LOCKED;
        else if (!connFilt) nxt = ST_WAIT;
      end
      default: nxt = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= nxt;
  end

  assign strobe.clrFilt = uvloPri;
  assign strobe.grant   = (state == ST_ACTIVE);

  AST_ACTIVE_VIA_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_ACTIVE) |-> $past(state) == ST_WAIT); // R6
  AST_ACTIVE_NEEDS_CONN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE) |-> $past(connFilt)); // R4
  AST_LOCK_LEAVES_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    lockAny |=> state != ST_ACTIVE); // R7
endmodule

// File: rtl/hsseq_dp.sv
module hsseq_dp
  import hsseq_pkg::*;
#(
  parameter bit DUAL_SUPPLY = 1'b1,
  parameter int FILT_CYCLES = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       uvloPri,
  input  logic       uvloSec,
  input  logic       connRaw,
  input  seqStrobe_t strobe,
  output logic       connFilt,
  output logic       prechargeBp,
  output logic       prechargeCard,
  output logic       ifaceEn
);
  localparam int CNT_W = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic lockAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      connFilt <= 1'b0;
    end else if (strobe.clrFilt) begin
      cnt      <= '0;
      connFilt <= 1'b0;
    end else if (connRaw != connFilt) begin
      if (cnt == CNT_LAST) begin
        cnt      <= '0;
        connFilt <= connRaw;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  generate
    if (DUAL_SUPPLY) begin : g_dual
      assign prechargeCard = uvloSec;
      assign lockAny       = uvloPri | uvloSec;
    end else begin : g_single
      assign prechargeCard = uvloPri;
      assign lockAny       = uvloPri;
    end
  endgenerate

  assign prechargeBp = uvloPri;
  assign ifaceEn     = strobe.grant & connFilt & ~lockAny;

  AST_FILT_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(connFilt) |-> ($past(strobe.clrFilt) || $past(cnt) == CNT_LAST)); // R5
  AST_FILT_CLEARED_IN_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    uvloPri |=> !connFilt); // R9
  AST_EN_NO_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN)
    ifaceEn |-> (!prechargeBp && !prechargeCard)); // R4
  AST_EN_LOW_IN_RESET: assert property (@(posedge clk)
    !rstN |-> !ifaceEn); // R1
endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq
  import hsseq_pkg::*;
#(
  parameter bit DUAL_SUPPLY = 1'b1,
  parameter int FILT_CYCLES = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic uvloPri,
  input  logic uvloSec,
  input  logic connRaw,
  output logic prechargeBp,
  output logic prechargeCard,
  output logic ifaceEn
);
  seqStrobe_t strobe;
  logic connFilt;

  hsseq_ctrl #(.DUAL_SUPPLY(DUAL_SUPPLY)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .uvloPri  (uvloPri),
    .uvloSec  (uvloSec),
    .connFilt (connFilt),
    .strobe   (strobe)
  );

  hsseq_dp #(.DUAL_SUPPLY(DUAL_SUPPLY), .FILT_CYCLES(FILT_CYCLES)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .uvloPri       (uvloPri),
    .uvloSec       (uvloSec),
    .connRaw       (connRaw),
    .strobe        (strobe),
    .connFilt      (connFilt),
    .prechargeBp   (prechargeBp),
    .prechargeCard (prechargeCard),
    .ifaceEn       (ifaceEn)
  );
endmodule

// File: tb/sim_hotswap_seq.sv
module sim_hotswap_seq;
  localparam int FILT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvloPri = 1'b1;
  logic uvloSec = 1'b1;
  logic connRaw = 1'b0;
  logic bpD, cardD, enD, bpS, cardS, enS;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [2:0] expD;
    logic [2:0] expS;
    string      tag;
  } item_t;
  item_t sbQ[$];

  always #10 clk = ~clk;   // 50 MHz

  hotswap_seq #(.DUAL_SUPPLY(1'b1), .FILT_CYCLES(FILT)) u0 (
    .clk(clk), .rstN(rstN), .uvloPri(uvloPri), .uvloSec(uvloSec),
    .connRaw(connRaw), .prechargeBp(bpD), .prechargeCard(cardD), .ifaceEn(enD));

  hotswap_seq #(.DUAL_SUPPLY(1'b0), .FILT_CYCLES(FILT)) u1 (
    .clk(clk), .rstN(rstN), .uvloPri(uvloPri), .uvloSec(uvloSec),
    .connRaw(connRaw), .prechargeBp(bpS), .prechargeCard(cardS), .ifaceEn(enS));

  // monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        checks++;
        if ({bpD, cardD, enD} !== it.expD) begin
          failures++;
          $display("FAIL %s dual-variant act=%b exp=%b", it.tag, {bpD, cardD, enD}, it.expD);
        end
        checks++;
        if ({bpS, cardS, enS} !== it.expS) begin
          failures++;
          $display("FAIL %s single-variant act=%b exp=%b", it.tag, {bpS, cardS, enS}, it.expS);
        end
      end
    end
  end

  task automatic drive(input logic p, input logic s, input logic c);
    @(posedge clk);
    #1;
    uvloPri = p;
    uvloSec = s;
    connRaw = c;
  endtask

  task automatic expectAfter(input int n, input logic [2:0] eD, input logic [2:0] eS,
                             input string tag);
    item_t it;
    repeat (n) @(posedge clk);
    it.expD = eD;
    it.expS = eS;
    it.tag  = tag;
    sbQ.push_back(it);
  endtask

  function automatic logic [2:0] model(input bit dual, input logic p, input logic s,
                                       input logic c);
    logic card, en;
    card = dual ? s : p;
    en   = !p && !(dual && s) && c;
    return {p, card, en};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(posedge clk); #1;
    expectAfter(0, 3'b110, 3'b110, "R1 reset");
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R9: connect while in lockout is not seen
    drive(1, 1, 1);
    expectAfter(20, 3'b110, 3'b110, "R9 connect during lockout");

    // primary released, secondary still locked
    drive(0, 1, 1);
    expectAfter(0, 3'b010, 3'b000, "R2 R3 precharge follows flags");
    expectAfter(FILT, 3'b010, 3'b000, "R9 filter restarts after release");
    expectAfter(1, 3'b010, 3'b001, "R9 R10 enable after full window");

    // secondary released: filter already high in dual variant
    drive(0, 0, 1);
    expectAfter(0, 3'b000, 3'b001, "R3 card precharge off");
    expectAfter(1, 3'b000, 3'b001, "R4 wait state first");
    expectAfter(1, 3'b001, 3'b001, "R4 enable after lockout clear");

    // secondary reasserts: dual drops at once, single unaffected
    drive(0, 1, 1);
    expectAfter(0, 3'b010, 3'b001, "R7 R10 secondary reassert");
    drive(0, 0, 1);
    expectAfter(5, 3'b001, 3'b001, "R4 recover");

    // short connect glitch (5 cycles) ignored
    drive(0, 0, 0);
    expectAfter(4, 3'b001, 3'b001, "R5 glitch in progress");
    drive(0, 0, 1);
    expectAfter(12, 3'b001, 3'b001, "R5 glitch ignored");

    // connect loss
    drive(0, 0, 0);
    expectAfter(FILT - 1, 3'b001, 3'b001, "R8 still enabled");
    expectAfter(1, 3'b000, 3'b000, "R8 connect lost");

    // reconnect
    drive(0, 0, 1);
    expectAfter(FILT, 3'b000, 3'b000, "R6 not yet enabled");
    expectAfter(1, 3'b001, 3'b001, "R6 enable timing");

    // primary reasserts while active
    drive(1, 0, 1);
    expectAfter(0, 3'b100, 3'b110, "R7 primary reassert");
    drive(0, 0, 1);
    expectAfter(FILT, 3'b000, 3'b000, "R9 filter cleared by lockout");
    expectAfter(1, 3'b001, 3'b001, "R9 enable after release");

    // random insertion/removal steps, steady-state checks
    for (int i = 0; i < 30; i++) begin
      logic p, s, c;
      p = 1'($urandom_range(0, 1));
      s = 1'($urandom_range(0, 1));
      c = 1'($urandom_range(0, 1));
      drive(p, s, c);
      expectAfter(FILT + 3, model(1'b1, p, s, c), model(1'b0, p, s, c),
                  "R4 R10 random step");
    end

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule